// File: doc/BRIEF.md
# BCD Digit Combination Lock

This block is a sequential lock that opens on a fixed three-digit combination entered as binary-coded-decimal digits. Each digit is offered on a 4-bit input with a one-cycle valid strobe. A purely combinational matcher compares the digit against the code expected for the current step. The controller sees only the match result. It then moves one step forward, opens after the last digit, or falls into a sticky error state.

The combination is a build-time parameter. By default it is 5, then 7, then 1. The controller keeps one flip-flop per state: one wait state per digit, plus an open state and an error state. The open and error outputs come straight from their state flops. Once the lock has opened or failed, it only leaves that state through reset.

Top module: `bcd_lock`

## Requirements
- R1: During and after reset (active-low `rst_ni`), the lock waits for the first digit, and both `open_o` and `err_o` are 0.
- R2: When the digits 5, 7, 1 (codes 4'b0101, 4'b0111, 4'b0001) are strobed in that order with no wrong digit between them, `open_o` rises on the clock edge that takes the third digit.
- R3: A strobed digit that differs from the digit expected at the current step (first, second or third) raises `err_o` on that clock edge.
- R4: A strobed code from 10 to 15 counts as a mismatch at every step and raises `err_o`.
- R5: On a cycle with `digit_vld_i` low, the state is held, whatever value `digit_i` has.
- R6: Once `open_o` is 1, it stays 1 until reset, whatever is strobed.
- R7: Once `err_o` is 1, it stays 1 until reset, even if the correct combination is entered afterwards.
- R8: Exactly one state flop is set in every cycle, so `open_o` and `err_o` are never both 1.
- R9: Each strobed digit moves the lock at most one step, so `open_o` never rises before the third accepted digit.
- R10: Reset in the middle of a sequence discards the digits already accepted, and matching starts again at the first digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| digit_i | input | 4 | BCD digit offered for the current step |
| digit_vld_i | input | 1 | Strobe: `digit_i` is taken on this edge |
| open_o | output | 1 | Lock open (sticky until reset) |
| err_o | output | 1 | Wrong or invalid digit seen (sticky until reset) |

## Verification
The assertions check on every cycle that the state register is one-hot, that `open_o` and `err_o` never coincide, and that both are sticky. They also check that an idle cycle leaves the state untouched, that an out-of-range code leads to the error state, and that the last correct digit opens the lock. Only the bench scenarios can show the order-dependent behaviour: the full correct sequence, a failure placed at each of the three positions, a reset that discards partial progress, and long random runs compared against a step-counting model.

// File: rtl/bcd_lock_pkg.sv
package bcd_lock_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned BCD_MAX = 9;
  typedef logic [DIGIT_W-1:0] bcd_t;
endpackage

// File: rtl/bcd_digit_match.sv
module bcd_digit_match
  import bcd_lock_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 3,
  parameter logic [NUM_DIGITS*DIGIT_W-1:0] CODE = {4'd1, 4'd7, 4'd5}
) (
  input  bcd_t                  digit_i,
  input  logic [NUM_DIGITS-1:0] step_i,
  output logic                  match_o
);
  logic                  is_bcd;
  logic [NUM_DIGITS-1:0] hit;

  assign is_bcd = (digit_i <= bcd_t'(BCD_MAX));

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_step
    assign hit[k] = is_bcd && (digit_i == CODE[k*DIGIT_W +: DIGIT_W]);
  end

  assign match_o = |(hit & step_i);
endmodule

// File: rtl/bcd_lock_fsm.sv
module bcd_lock_fsm #(
  parameter int unsigned NUM_DIGITS = 3,
  localparam int unsigned NS = NUM_DIGITS + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic          match_i,
  output logic [NS-1:0] state_o
);
  localparam int unsigned S_ERR = NUM_DIGITS + 1;

  logic [NS-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (vld_i) begin
      for (int k = 0; k < NUM_DIGITS; k++) begin
        if (state_q[k]) begin
          state_d[k] = 1'b0;
          if (match_i) state_d[k+1] = 1'b1;  // last step lands on open
          else         state_d[S_ERR] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= NS'(1);
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/bcd_lock.sv
module bcd_lock
  import bcd_lock_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 3,
  parameter logic [NUM_DIGITS*DIGIT_W-1:0] CODE = {4'd1, 4'd7, 4'd5}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIGIT_W-1:0] digit_i,
  input  logic               digit_vld_i,
  output logic               open_o,
  output logic               err_o
);
  localparam int unsigned NS = NUM_DIGITS + 2;

  logic [NS-1:0] state_q;
  logic          match;

  bcd_digit_match #(.NUM_DIGITS(NUM_DIGITS), .CODE(CODE)) u_match (
    .digit_i (digit_i),
    .step_i  (state_q[NUM_DIGITS-1:0]),
    .match_o (match)
  );

  bcd_lock_fsm #(.NUM_DIGITS(NUM_DIGITS)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (digit_vld_i),
    .match_i (match),
    .state_o (state_q)
  );

  assign open_o = state_q[NUM_DIGITS];
  assign err_o  = state_q[NUM_DIGITS+1];
endmodule

// File: rtl/bcd_lock_chk.sv
module bcd_lock_chk
  import bcd_lock_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 3,
  parameter logic [NUM_DIGITS*DIGIT_W-1:0] CODE = {4'd1, 4'd7, 4'd5},
  localparam int unsigned NS = NUM_DIGITS + 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [DIGIT_W-1:0] digit_i,
  input logic               digit_vld_i,
  input logic               open_o,
  input logic               err_o,
  input logic [NS-1:0]      state_q
);
  localparam logic [DIGIT_W-1:0] LAST = CODE[(NUM_DIGITS-1)*DIGIT_W +: DIGIT_W];

  AST_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_q) == 1); // R8
  AST_OUT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(open_o && err_o)); // R8
  AST_OPEN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_o |=> open_o); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !digit_vld_i |=> $stable(state_q)); // R5
  AST_BAD_BCD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digit_vld_i && digit_i > 4'd9 && !open_o) |=> err_o); // R4
  AST_LAST_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digit_vld_i && state_q[NUM_DIGITS-1] && digit_i == LAST) |=> open_o); // R2
  AST_NO_EARLY_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_o && !state_q[NUM_DIGITS-1]) |=> !open_o); // R9
endmodule

bind bcd_lock bcd_lock_chk #(.NUM_DIGITS(NUM_DIGITS), .CODE(CODE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .digit_i     (digit_i),
  .digit_vld_i (digit_vld_i),
  .open_o      (open_o),
  .err_o       (err_o),
  .state_q     (state_q)
);

// File: tb/bcd_lock_test.sv
`timescale 1ns/1ps
module bcd_lock_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] digit = 4'd0;
  logic       vld = 1'b0;
  logic       open_w, err_w;

  int tests = 0;
  int fails = 0;
  int ms = 0;  // model: 0..2 waiting for digit, 3 open, 4 error
  int code [3] = '{5, 7, 1};

  always #4 clk = ~clk;  // 125 MHz

  bcd_lock uut (
    .clk_i(clk), .rst_ni(rst_n), .digit_i(digit), .digit_vld_i(vld),
    .open_o(open_w), .err_o(err_w)
  );

  function automatic int next_ms(int s, int d, bit v);
    if (!v || s > 2) return s;
    return (d == code[s]) ? s + 1 : 4;
  endfunction

  task automatic check(string req);
    bit eo = (ms == 3);
    bit ee = (ms == 4);
    tests++;
    if (open_w !== eo || err_w !== ee) begin
      fails++;
      $display("FAIL %s: open=%b err=%b expected open=%b err=%b", req, open_w, err_w, eo, ee);
    end
  endtask

  // drive one cycle; check after the edge, away from it
  task automatic cyc(int d, bit v, string req);
    @(negedge clk);
    digit = 4'(d);
    vld = v;
    ms = next_ms(ms, d, v);
    @(negedge clk);
    vld = 1'b0;
    check(req);
  endtask

  task automatic do_reset(string req);
    @(negedge clk);
    rst_n = 1'b0;
    vld = 1'b0;
    ms = 0;
    @(negedge clk);
    check(req);
    rst_n = 1'b1;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0711));
    do_reset("R1");

    // correct sequence
    cyc(5, 1, "R9"); cyc(7, 1, "R9"); cyc(1, 1, "R2");
    cyc(3, 1, "R6"); cyc(15, 1, "R6"); cyc(5, 0, "R6");

    // failure at each position
    do_reset("R1"); cyc(4, 1, "R3");
    do_reset("R1"); cyc(5, 1, "R3"); cyc(6, 1, "R3");
    do_reset("R1"); cyc(5, 1, "R3"); cyc(7, 1, "R3"); cyc(9, 1, "R3");
    cyc(5, 1, "R7"); cyc(7, 1, "R7"); cyc(1, 1, "R7");

    // invalid BCD codes at each step
    for (int c = 10; c < 16; c++) begin
      do_reset("R1");
      for (int p = 0; p < c % 3; p++) cyc(code[p], 1, "R4");
      cyc(c, 1, "R4");
    end

    // idle cycles ignore data
    do_reset("R1");
    cyc(5, 1, "R5"); cyc(9, 0, "R5"); cyc(12, 0, "R5");
    cyc(7, 1, "R5"); cyc(0, 0, "R5"); cyc(1, 1, "R5");

    // reset mid-sequence discards progress
    do_reset("R1"); cyc(5, 1, "R10"); cyc(7, 1, "R10");
    do_reset("R10"); cyc(1, 1, "R10");
    do_reset("R10"); cyc(5, 1, "R10"); cyc(7, 1, "R10"); cyc(1, 1, "R10");

    // random sessions against the model
    for (int s = 0; s < 300; s++) begin
      do_reset("R1");
      for (int i = 0; i < 8; i++) begin
        int d;
        bit v;
        v = ($urandom % 4) != 0;
        if (ms <= 2 && ($urandom % 10) < 7) d = code[ms];
        else d = $urandom % 16;
        cyc(d, v, "R9");
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule